// File: doc/BRIEF.md
# Edge/Level Interrupt Source Capture

This block samples a vector of interrupt lines once per clock and keeps one pending bit per source. A per-source trigger-mode bit picks how the pending bit behaves. In level mode the pending bit simply tracks the line. In edge mode a low-to-high transition latches the pending bit, and it stays latched until software clears it. A stored copy of each line's previous sampled level is what makes the transition visible.

Software programs the trigger modes and issues clears as 32-bit half words, one strobe for each half. For every source the block also produces single-cycle raise and lower pulses whenever the line changes. A downstream dispatcher uses these pulses together with the pending vector.

Top module: `irq_capture`

## Requirements
- R1: After reset, pending, the stored previous levels and every trigger-mode bit are 0, so all sources start in level mode and raise_evt and lower_evt are 0.
- R2: For a source whose mode bit is 1 (edge mode), a high sample sets its pending bit only when the previous sample of that line was low. A line that stays high does not set the bit again.
- R3: In edge mode a low sample leaves the pending bit unchanged and only updates the stored previous level.
- R4: For a source whose mode bit is 0 (level mode), the pending bit equals the line value sampled at the most recent clock edge.
- R5: When a clear strobe is active, the clear data bits that are 1 force the pending bit of the matching edge-mode sources to 0 at the next edge. Level-mode sources ignore the clear.
- R6: clr_wr_lo applies clr_wdata bit k to source k, and clr_wr_hi applies clr_wdata bit k to source k+32. A half whose strobe is low is unaffected.
- R7: cfg_wr_lo loads mode bits 0–31 and cfg_wr_hi loads mode bits 32–63 from cfg_wdata, leaving the other half unchanged. edge_mode shows the mode register. The new mode governs samples from the edge after the write.
- R8: raise_evt[i] (lower_evt[i]) is 1 for exactly the one cycle after an edge at which line i was sampled high (low) while its previous sample was low (high).
- R9: If a rising edge and a clear for the same edge-mode source fall on the same clock edge, the clear wins. The pending bit stays 0 until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Interrupt lines, sampled every clock |
| cfg_wr_lo | input | 1 | Load mode bits of the lower half from cfg_wdata |
| cfg_wr_hi | input | 1 | Load mode bits of the upper half from cfg_wdata |
| cfg_wdata | input | NUM_SRC/2 | Mode data, 1 = edge, 0 = level |
| clr_wr_lo | input | 1 | Apply clr_wdata as clear word for the lower half |
| clr_wr_hi | input | 1 | Apply clr_wdata as clear word for the upper half |
| clr_wdata | input | NUM_SRC/2 | Clear word, 1 = clear that source |
| pending | output | NUM_SRC | Pending request vector |
| edge_mode | output | NUM_SRC | Current trigger-mode register |
| raise_evt | output | NUM_SRC | One-cycle pulse on a rising line |
| lower_evt | output | NUM_SRC | One-cycle pulse on a falling line |

## Verification
The hardest situation to reach from the ports is a clear that lands on the same edge as a fresh rising transition of an edge-mode line. After that edge the line is high, its stored level is high and its pending bit is 0, and the bit must stay 0 while the line holds. The stimulus table drops the line, raises it again in the exact cycle that carries the clear strobe, and then holds it high for another cycle. In the same walk, a level-mode source in the same clear word stays high, which shows that the clear does not touch it.

// File: rtl/irq_capture_pkg.sv
`timescale 1ns/1ps
package irq_capture_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    // Next pending value of one source
    function automatic logic next_pending(
        input trig_mode_e mode,
        input logic       lvl,
        input logic       rise,
        input logic       pend,
        input logic       clr
    );
        if (mode == TRIG_EDGE) begin
            return (pend | rise) & ~clr;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/irq_half_merge.sv
`timescale 1ns/1ps
module irq_half_merge #(
    parameter int HALF_W = 32
) (
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   sel_o,
    output logic [2*HALF_W-1:0]   val_o
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] sel_w;

    assign sel_w = {{HALF_W{wr_hi}}, {HALF_W{wr_lo}}};
    assign sel_o = sel_w;
    assign val_o = {wdata, wdata};
endmodule

// File: rtl/irq_src_cell.sv
`timescale 1ns/1ps
module irq_src_cell
    import irq_capture_pkg::*;
(
    input  logic level_i,
    input  logic last_q_i,
    input  logic pend_q_i,
    input  logic edge_i,
    input  logic clr_i,
    output logic pend_d_o,
    output logic last_d_o,
    output logic rise_o,
    output logic fall_o
);
    logic rise_w;

    assign rise_w   = level_i & ~last_q_i;
    assign rise_o   = rise_w;
    assign fall_o   = ~level_i & last_q_i;
    assign last_d_o = level_i;
    assign pend_d_o = next_pending(trig_mode_e'(edge_i), level_i, rise_w, pend_q_i, clr_i);
endmodule

// File: rtl/irq_capture.sv
`timescale 1ns/1ps
module irq_capture #(
    parameter int NUM_SRC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic                 cfg_wr_lo,
    input  logic                 cfg_wr_hi,
    input  logic [NUM_SRC/2-1:0] cfg_wdata,
    input  logic                 clr_wr_lo,
    input  logic                 clr_wr_hi,
    input  logic [NUM_SRC/2-1:0] clr_wdata,
    output logic [NUM_SRC-1:0]   pending,
    output logic [NUM_SRC-1:0]   edge_mode,
    output logic [NUM_SRC-1:0]   raise_evt,
    output logic [NUM_SRC-1:0]   lower_evt
);
    localparam int HALF_W = NUM_SRC / 2;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] last;
        logic [NUM_SRC-1:0] mode;
        logic [NUM_SRC-1:0] raise;
        logic [NUM_SRC-1:0] lower;
    } cap_state_t;

    cap_state_t st_d, st_q;

    logic [NUM_SRC-1:0] cfg_sel, cfg_val;
    logic [NUM_SRC-1:0] clr_sel, clr_val;
    logic [NUM_SRC-1:0] cell_pend, cell_last, cell_rise, cell_fall;

    irq_half_merge #(.HALF_W(HALF_W)) u_cfg_merge (
        .wr_lo (cfg_wr_lo),
        .wr_hi (cfg_wr_hi),
        .wdata (cfg_wdata),
        .sel_o (cfg_sel),
        .val_o (cfg_val)
    );

    irq_half_merge #(.HALF_W(HALF_W)) u_clr_merge (
        .wr_lo (clr_wr_lo),
        .wr_hi (clr_wr_hi),
        .wdata (clr_wdata),
        .sel_o (clr_sel),
        .val_o (clr_val)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_src_cell u_cell (
            .level_i  (irq_in[i]),
            .last_q_i (st_q.last[i]),
            .pend_q_i (st_q.pend[i]),
            .edge_i   (st_q.mode[i]),
            .clr_i    (clr_sel[i] & clr_val[i]),
            .pend_d_o (cell_pend[i]),
            .last_d_o (cell_last[i]),
            .rise_o   (cell_rise[i]),
            .fall_o   (cell_fall[i])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.pend  = cell_pend;
        st_d.last  = cell_last;
        st_d.raise = cell_rise;
        st_d.lower = cell_fall;
        st_d.mode  = (st_q.mode & ~cfg_sel) | (cfg_val & cfg_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending   = st_q.pend;
    assign edge_mode = st_q.mode;
    assign raise_evt = st_q.raise;
    assign lower_evt = st_q.lower;
endmodule

// File: rtl/irq_capture_chk.sv
`timescale 1ns/1ps
module irq_capture_chk #(
    parameter int NUM_SRC = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   irq_in,
    input logic                 cfg_wr_lo,
    input logic                 cfg_wr_hi,
    input logic [NUM_SRC/2-1:0] clr_wdata,
    input logic                 clr_wr_lo,
    input logic                 clr_wr_hi,
    input logic [NUM_SRC-1:0]   pending,
    input logic [NUM_SRC-1:0]   edge_mode,
    input logic [NUM_SRC-1:0]   raise_evt,
    input logic [NUM_SRC-1:0]   lower_evt
);
    localparam int HALF_W = NUM_SRC / 2;

    logic [NUM_SRC-1:0] prev_in;
    logic [NUM_SRC-1:0] clr_word;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_in <= '0;
        else        prev_in <= irq_in;
    end

    always_comb begin
        clr_word = '0;
        if (clr_wr_lo) clr_word[HALF_W-1:0]       = clr_wdata;
        if (clr_wr_hi) clr_word[NUM_SRC-1:HALF_W] = clr_wdata;
    end

    AST_EDGE_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & $past(edge_mode)
                   & ~($past(irq_in) & ~$past(prev_in))) == '0)); // R2

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pending) & $past(edge_mode) & ~$past(clr_word) & ~pending) == '0)); // R3

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pending ^ $past(irq_in)) & ~$past(edge_mode)) == '0)); // R4

    AST_CLEAR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & $past(clr_word) & $past(edge_mode)) == '0)); // R5

    AST_MODE_LO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_lo |=> $stable(edge_mode[HALF_W-1:0])); // R7

    AST_MODE_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_hi |=> $stable(edge_mode[NUM_SRC-1:HALF_W])); // R7

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_evt & lower_evt) == '0); // R8
endmodule

bind irq_capture irq_capture_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .cfg_wr_lo (cfg_wr_lo),
    .cfg_wr_hi (cfg_wr_hi),
    .clr_wdata (clr_wdata),
    .clr_wr_lo (clr_wr_lo),
    .clr_wr_hi (clr_wr_hi),
    .pending   (pending),
    .edge_mode (edge_mode),
    .raise_evt (raise_evt),
    .lower_evt (lower_evt)
);

// File: tb/irq_capture_bench.sv
`timescale 1ns/1ps
module irq_capture_bench;
    localparam int N = 64;
    localparam logic [63:0] B0  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] B20 = 64'h0000_0000_0010_0000;
    localparam logic [63:0] B40 = 64'h0000_0100_0000_0000;
    localparam logic [63:0] B63 = 64'h8000_0000_0000_0000;

    typedef struct packed {
        logic [63:0] irq;
        logic        clo;
        logic        chi;
        logic [31:0] cdat;
        logic [63:0] exp_pend;
        logic [63:0] exp_rise;
        logic [63:0] exp_fall;
    } vec_t;

    // Sources 0 and 63 are edge mode, 20 and 40 level mode
    localparam vec_t VECS [8] = '{
        '{B0|B20|B40|B63, 1'b0, 1'b0, 32'h0,         B0|B20|B40|B63, B0|B20|B40|B63, 64'h0},
        '{B63,            1'b0, 1'b0, 32'h0,         B0|B63,         64'h0,          B0|B20|B40},
        '{B20|B63,        1'b1, 1'b0, 32'h0010_0001, B20|B63,        B20,            64'h0},
        '{B20|B40|B63,    1'b0, 1'b1, 32'h8000_0100, B20|B40,        B40,            64'h0},
        '{B0|B20|B40|B63, 1'b1, 1'b0, 32'h0000_0001, B20|B40,        B0,             64'h0},
        '{B0|B20|B40|B63, 1'b0, 1'b0, 32'h0,         B20|B40,        64'h0,          64'h0},
        '{B20|B40,        1'b0, 1'b0, 32'h0,         B20|B40,        64'h0,          B0|B63},
        '{B0|B20|B40|B63, 1'b0, 1'b0, 32'h0,         B0|B20|B40|B63, B0|B63,         64'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic          cfg_wr_lo = 1'b0, cfg_wr_hi = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          clr_wr_lo = 1'b0, clr_wr_hi = 1'b0;
    logic [31:0]   clr_wdata = '0;
    logic [N-1:0]  pending, edge_mode, raise_evt, lower_evt;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_capture #(.NUM_SRC(N)) u_irq_capture (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_wr_lo(cfg_wr_lo), .cfg_wr_hi(cfg_wr_hi), .cfg_wdata(cfg_wdata),
        .clr_wr_lo(clr_wr_lo), .clr_wr_hi(clr_wr_hi), .clr_wdata(clr_wdata),
        .pending(pending), .edge_mode(edge_mode),
        .raise_evt(raise_evt), .lower_evt(lower_evt)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge: drive, let one posedge pass, return at next negedge
    task automatic apply(input logic [63:0] irq, input logic cl, input logic ch, input logic [31:0] cd);
        irq_in    = irq;
        clr_wr_lo = cl;
        clr_wr_hi = ch;
        clr_wdata = cd;
        @(negedge clk);
        clr_wr_lo = 1'b0;
        clr_wr_hi = 1'b0;
    endtask

    initial begin
        #160000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check64("R1 pending", pending, 64'h0);
        check64("R1 mode", edge_mode, 64'h0);
        check64("R1 raise", raise_evt, 64'h0);
        check64("R1 lower", lower_evt, 64'h0);
        rst_n = 1'b1;

        // Default level mode after reset
        apply(64'h20, 1'b0, 1'b0, 32'h0);
        check64("R4 level high", pending, 64'h20);
        check64("R8 raise", raise_evt, 64'h20);
        apply(64'h0, 1'b0, 1'b0, 32'h0);
        check64("R4 level low", pending, 64'h0);
        check64("R8 lower", lower_evt, 64'h20);

        // Mode halves
        cfg_wdata = 32'h0000_FFFF; cfg_wr_lo = 1'b1;
        @(negedge clk);
        cfg_wr_lo = 1'b0;
        check64("R7 lo write", edge_mode, 64'h0000_0000_0000_FFFF);
        cfg_wdata = 32'hFFFF_0000; cfg_wr_hi = 1'b1;
        @(negedge clk);
        cfg_wr_hi = 1'b0;
        check64("R7 hi write keeps lo", edge_mode, 64'hFFFF_0000_0000_FFFF);

        // Vector walk (R2 R3 R4 R5 R6 R8 R9)
        for (int v = 0; v < 8; v++) begin
            apply(VECS[v].irq, VECS[v].clo, VECS[v].chi, VECS[v].cdat);
            check64($sformatf("R2/R3/R4/R5/R6/R9 pending v%0d", v), pending, VECS[v].exp_pend);
            check64($sformatf("R8 raise v%0d", v), raise_evt, VECS[v].exp_rise);
            check64($sformatf("R8 lower v%0d", v), lower_evt, VECS[v].exp_fall);
        end

        // Reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check64("R1 mid reset pending", pending, 64'h0);
        check64("R1 mid reset mode", edge_mode, 64'h0);
        irq_in = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule